// File: doc/BRIEF.md
# Burst Engine with Clock Suspend

This block is the core of a synchronous memory device. It takes a two-bit command (no-op, open a bank, read, write) together with a bank number and a column. It serves fixed-length bursts from a small internal word array. The data bus is split into an input port, an output port and an output-enable. An active-high clock-enable input lets the system freeze a burst partway through. The enable is registered through two stages, so the engine stops advancing two edges after the enable is sampled low. It starts again two edges after the enable is sampled high. While it is frozen, the word on the outputs stays driven, write data is not stored, and any command that arrives is dropped rather than queued. A low enable has no effect until at least one bank is open.

Each burst walks sequentially through a block of columns aligned to the burst length, wrapping inside that block. A new read or write cancels any burst of the other kind that is still in flight. A parameter selects between a direct data path and a registered-module data path. The registered path adds one cycle to both read and write data. Mode programming, refresh, precharge and idle power-down are not part of the block.

Top module: `sdr_burst_engine`

## Requirements
- R1: While rst_n is low and after its release, dq_oe is low and every bank is closed. The engine is running: the first two edges after reset are not frozen.
- R2: A read (cmd = 2'b10) accepted at edge t puts word i of the burst on dq_out with dq_oe high after the (CAS_LAT + i)-th advancing edge after t. Word i is at column c advanced i times within its BURST_LEN-aligned block, for example 3 then 2. After the last word, dq_oe falls on the next advancing edge.
- R3: A write (cmd = 2'b11) accepted at edge t stores dq_in sampled at t as the first word. Each later advancing edge stores the next word, wrapping in the same way as a read.
- R4: When cke is sampled low at edge e while a bank is open, edges e+2 onward do not advance: no burst counter, latency countdown or state moves.
- R5: When cke is sampled high at edge m, edges m+2 onward advance again.
- R6: While frozen during a read, dq_out and dq_oe keep their values. The burst resumes with the next word.
- R7: While frozen during a write, dq_in is not stored. The burst resumes with the next word at the next advancing edge.
- R8: A command presented on a frozen edge is discarded and has no later effect.
- R9: A low cke sampled while no bank is open causes no freeze. An open-bank command (cmd = 2'b01) given then is accepted.
- R10: A read or write to a bank that has not been opened is ignored.
- R11: With REGISTERED = 1, read words appear one advancing edge later than in R2. The first write word is sampled at the first advancing edge after the write command instead of at the command edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke | input | 1 | Clock enable, high to run |
| cmd | input | 2 | 00 no-op, 01 open bank, 10 read, 11 write |
| bank | input | BANK_W | Bank number for the command |
| col | input | COL_W | Start column for read or write |
| dq_in | input | DATA_W | Write data |
| dq_out | output | DATA_W | Read data |
| dq_oe | output | 1 | High while dq_out carries a read word |

## Verification
The assertions assume that cke and the command pins are stable around the edge, and that a new read or write is never issued while an earlier burst still owns the data path. They also assume BURST_LEN is a power of two of at least 2. The stimulus drives every input on the falling edge. It starts each burst only after the previous one and any freeze have fully drained. It reads back only columns that were written earlier. It sweeps every freeze start offset from 0 to 5 edges after the command and freeze lengths of 1 to 3 edges against a direct and a registered instance side by side.

// File: rtl/sdr_burst_pkg.sv
package sdr_burst_pkg;
  typedef enum logic [1:0] {
    CMD_NOP = 2'b00,
    CMD_ACT = 2'b01,
    CMD_RD  = 2'b10,
    CMD_WR  = 2'b11
  } sdr_cmd_e;
endpackage

// File: rtl/sdr_cke_pipe.sv
module sdr_cke_pipe (
  input  logic clk,
  input  logic rst_n,
  input  logic cke,
  input  logic any_open,
  output logic adv
);
  logic stage1, stage2;

  // a low enable only counts once a bank is open
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= 1'b1;
      stage2 <= 1'b1;
    end else begin
      stage1 <= cke | ~any_open;
      stage2 <= stage1;
    end
  end

  assign adv = stage2;

  a_r4_entry_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (any_open && !cke) |-> ##2 !adv);
  a_r5_exit_delay: assert property (@(posedge clk) disable iff (!rst_n)
    cke |-> ##2 adv);
endmodule

// File: rtl/sdr_bank_track.sv
module sdr_bank_track
  import sdr_burst_pkg::*;
#(
  parameter int BANK_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  sdr_cmd_e          cmd,
  input  logic [BANK_W-1:0] bank,
  output logic [(1<<BANK_W)-1:0] open_mask,
  output logic              any_open
);
  localparam int NBANK = 1 << BANK_W;

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic is_open;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) is_open <= 1'b0;
      else if (adv && cmd == CMD_ACT && bank == BANK_W'(g)) is_open <= 1'b1;
    end
    assign open_mask[g] = is_open;
  end

  assign any_open = |open_mask;

  a_r8_banks_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(open_mask));
endmodule

// File: rtl/sdr_word_store.sv
module sdr_word_store #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/sdr_burst_seq.sv
module sdr_burst_seq
  import sdr_burst_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int BANK_W     = 1,
  parameter int COL_W      = 3,
  parameter int BURST_LEN  = 2,
  parameter int CAS_LAT    = 2,
  parameter int REGISTERED = 0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     adv,
  input  sdr_cmd_e                 cmd,
  input  logic [BANK_W-1:0]        bank,
  input  logic [COL_W-1:0]         col,
  input  logic [(1<<BANK_W)-1:0]   open_mask,
  input  logic [DATA_W-1:0]        dq_in,
  input  logic [DATA_W-1:0]        rdata,
  output logic [BANK_W+COL_W-1:0]  raddr,
  output logic                     we,
  output logic [BANK_W+COL_W-1:0]  waddr,
  output logic [DATA_W-1:0]        wdata,
  output logic [DATA_W-1:0]        dout,
  output logic                     oe
);
  localparam int BL_W    = $clog2(BURST_LEN);
  localparam int LEFT_W  = $clog2(BURST_LEN + 1);
  localparam int RD_WAIT = CAS_LAT - 1 + REGISTERED;
  localparam int WAIT_W  = $clog2(RD_WAIT + 2);

  function automatic logic [COL_W-1:0] colbump(input logic [COL_W-1:0] c);
    logic [COL_W-1:0] r;
    r = c;
    r[BL_W-1:0] = c[BL_W-1:0] + BL_W'(1);
    return r;
  endfunction

  logic [BANK_W-1:0] rd_bank, wr_bank;
  logic [COL_W-1:0]  rd_col, wr_col;
  logic [LEFT_W-1:0] rd_left, wr_left;
  logic [WAIT_W-1:0] rd_wait;
  logic [DATA_W-1:0] dout_q;
  logic              oe_q;

  logic bank_ok, rd_cmd, wr_cmd;
  assign bank_ok = open_mask[bank];
  assign rd_cmd  = adv && bank_ok && cmd == CMD_RD;
  assign wr_cmd  = adv && bank_ok && cmd == CMD_WR;

  // write start differs between direct and registered data paths
  logic [COL_W-1:0]  first_col;
  logic [LEFT_W-1:0] first_left;
  logic              beat_on_cmd;
  if (REGISTERED == 0) begin : g_direct
    assign first_col   = colbump(col);
    assign first_left  = LEFT_W'(BURST_LEN - 1);
    assign beat_on_cmd = 1'b1;
  end else begin : g_regd
    assign first_col   = col;
    assign first_left  = LEFT_W'(BURST_LEN);
    assign beat_on_cmd = 1'b0;
  end

  assign raddr = {rd_bank, rd_col};
  assign we    = (wr_cmd && beat_on_cmd) ||
                 (adv && !rd_cmd && !wr_cmd && wr_left != '0);
  assign waddr = wr_cmd ? {bank, col} : {wr_bank, wr_col};
  assign wdata = dq_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_bank <= '0;
      rd_col  <= '0;
      rd_left <= '0;
      rd_wait <= '0;
      dout_q  <= '0;
      oe_q    <= 1'b0;
    end else if (adv) begin
      if (rd_cmd) begin
        rd_bank <= bank;
        rd_col  <= col;
        rd_left <= LEFT_W'(BURST_LEN);
        rd_wait <= WAIT_W'(RD_WAIT);
        oe_q    <= 1'b0;
      end else if (wr_cmd) begin
        rd_left <= '0;
        oe_q    <= 1'b0;
      end else if (rd_wait != '0) begin
        rd_wait <= rd_wait - WAIT_W'(1);
      end else if (rd_left != '0) begin
        dout_q  <= rdata;
        oe_q    <= 1'b1;
        rd_col  <= colbump(rd_col);
        rd_left <= rd_left - LEFT_W'(1);
      end else begin
        oe_q    <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_bank <= '0;
      wr_col  <= '0;
      wr_left <= '0;
    end else if (adv) begin
      if (wr_cmd) begin
        wr_bank <= bank;
        wr_col  <= first_col;
        wr_left <= first_left;
      end else if (rd_cmd) begin
        wr_left <= '0;
      end else if (wr_left != '0) begin
        wr_col  <= colbump(wr_col);
        wr_left <= wr_left - LEFT_W'(1);
      end
    end
  end

  assign dout = dout_q;
  assign oe   = oe_q;

  a_r6_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> ($stable(dout_q) && $stable(oe_q)));
  a_r10_closed_read: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && cmd == CMD_RD && !bank_ok && rd_left == '0 && !oe_q) |=> !oe_q);
endmodule

// File: rtl/sdr_burst_engine.sv
module sdr_burst_engine
  import sdr_burst_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int BANK_W     = 1,
  parameter int COL_W      = 3,
  parameter int BURST_LEN  = 2,
  parameter int CAS_LAT    = 2,
  parameter int REGISTERED = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke,
  input  logic [1:0]        cmd,
  input  logic [BANK_W-1:0] bank,
  input  logic [COL_W-1:0]  col,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);
  localparam int ADDR_W = BANK_W + COL_W;
  localparam int NBANK  = 1 << BANK_W;

  sdr_cmd_e            cmd_e;
  logic                adv, any_open;
  logic [NBANK-1:0]    open_mask;
  logic                st_we;
  logic [ADDR_W-1:0]   st_waddr, st_raddr;
  logic [DATA_W-1:0]   st_wdata, st_rdata;

  assign cmd_e = sdr_cmd_e'(cmd);

  sdr_cke_pipe u_cke (
    .clk(clk), .rst_n(rst_n), .cke(cke), .any_open(any_open), .adv(adv)
  );

  sdr_bank_track #(.BANK_W(BANK_W)) u_banks (
    .clk(clk), .rst_n(rst_n), .adv(adv), .cmd(cmd_e), .bank(bank),
    .open_mask(open_mask), .any_open(any_open)
  );

  sdr_word_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .we(st_we), .waddr(st_waddr), .wdata(st_wdata),
    .raddr(st_raddr), .rdata(st_rdata)
  );

  sdr_burst_seq #(
    .DATA_W(DATA_W), .BANK_W(BANK_W), .COL_W(COL_W),
    .BURST_LEN(BURST_LEN), .CAS_LAT(CAS_LAT), .REGISTERED(REGISTERED)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .adv(adv), .cmd(cmd_e), .bank(bank), .col(col),
    .open_mask(open_mask), .dq_in(dq_in), .rdata(st_rdata),
    .raddr(st_raddr), .we(st_we), .waddr(st_waddr), .wdata(st_wdata),
    .dout(dq_out), .oe(dq_oe)
  );

  a_r7_no_store_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |-> !st_we);
endmodule

// File: tb/sdr_burst_engine_test.sv
module sdr_burst_engine_test;
  import sdr_burst_pkg::*;
  localparam int DW = 8, BW = 1, CW = 3, BL = 2, CL = 2;
  localparam int NCOL = 1 << CW;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, cke;
  logic [1:0] cmd;
  logic [BW-1:0] bank;
  logic [CW-1:0] col;
  logic [DW-1:0] din;
  logic [DW-1:0] dout0, dout1;
  logic oe0, oe1;

  sdr_burst_engine #(.DATA_W(DW), .BANK_W(BW), .COL_W(CW), .BURST_LEN(BL),
    .CAS_LAT(CL), .REGISTERED(0)) uut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cmd(cmd), .bank(bank), .col(col),
    .dq_in(din), .dq_out(dout0), .dq_oe(oe0));

  sdr_burst_engine #(.DATA_W(DW), .BANK_W(BW), .COL_W(CW), .BURST_LEN(BL),
    .CAS_LAT(CL), .REGISTERED(1)) uut_reg (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cmd(cmd), .bank(bank), .col(col),
    .dq_in(din), .dq_out(dout1), .dq_oe(oe1));

  int n_run = 0, n_fail = 0;
  logic [DW-1:0] model [2][2*NCOL];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic k, input logic [1:0] c, input int b,
                      input int cl, input logic [DW-1:0] d);
    cke = k; cmd = c; bank = BW'(b); col = CW'(cl); din = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int nextcol(input int c);
    return (c & ~(BL - 1)) | ((c + 1) & (BL - 1));
  endfunction

  function automatic logic [DW-1:0] wdat(input int s, input int L, input int b,
                                          input int c, input int j);
    return DW'(s * 37 + L * 11 + j * 3 + 5 + b * 101 + c * 7);
  endfunction

  task automatic read_sweep(input int s, input int L, input int b, input int c,
                            input string base);
    bit ck [15];
    int cnt = 0;
    for (int j = 0; j < 15; j++) ck[j] = !(j >= s && j < s + L);
    step(ck[0], CMD_RD, b, c, '0);
    check(oe0 == 1'b0, (base != "") ? base : "R2", int'(oe0), 0);
    check(oe1 == 1'b0, "R11", int'(oe1), 0);
    for (int j = 1; j < 15; j++) begin
      bit adv;
      string tag;
      step(ck[j], CMD_NOP, 0, 0, '0);
      adv = (j >= 2) ? ck[j-2] : 1'b1;
      if (adv) cnt++;
      tag = !adv ? "R4" : ((j >= 3 && !ck[j-3]) ? "R5" : "R2");
      for (int r = 0; r < 2; r++) begin
        int lat = CL + r;
        bit eoe = (cnt >= lat) && (cnt <= lat + BL - 1);
        logic aoe = r ? oe1 : oe0;
        logic [DW-1:0] ad = r ? dout1 : dout0;
        string t = (base != "") ? base : tag;
        if (r == 1) t = {t, "/R11"};
        if (!adv && eoe) t = {t, "/R6"};
        check(aoe == eoe, t, int'(aoe), int'(eoe));
        if (eoe) begin
          int cc = c;
          for (int i = 0; i < cnt - lat; i++) cc = nextcol(cc);
          check(ad == model[r][b * NCOL + cc], t, int'(ad),
                int'(model[r][b * NCOL + cc]));
        end
      end
    end
  endtask

  task automatic write_sweep(input int s, input int L, input int b, input int c,
                             input string base);
    bit ck [15];
    int cnt = 0;
    for (int j = 0; j < 15; j++) ck[j] = !(j >= s && j < s + L);
    step(ck[0], CMD_WR, b, c, wdat(s, L, b, c, 0));
    model[0][b * NCOL + c] = wdat(s, L, b, c, 0);
    for (int j = 1; j < 15; j++) begin
      bit adv;
      step(ck[j], CMD_NOP, 0, 0, wdat(s, L, b, c, j));
      adv = (j >= 2) ? ck[j-2] : 1'b1;
      if (adv) begin
        cnt++;
        for (int r = 0; r < 2; r++) begin
          int i = cnt - r;
          if (i >= 0 && i < BL) begin
            int cc = c;
            for (int q = 0; q < i; q++) cc = nextcol(cc);
            model[r][b * NCOL + cc] = wdat(s, L, b, c, j);
          end
        end
      end
    end
    read_sweep(99, 0, b, c, base);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int r = 0; r < 2; r++)
      for (int a = 0; a < 2 * NCOL; a++) model[r][a] = '0;
    rst_n = 1'b0; cke = 1'b1; cmd = CMD_NOP; bank = '0; col = '0; din = '0;
    repeat (3) @(negedge clk);
    check(oe0 == 1'b0, "R1", int'(oe0), 0);
    check(oe1 == 1'b0, "R1", int'(oe1), 0);
    rst_n = 1'b1;
    step(1'b1, CMD_NOP, 0, 0, '0);
    check(oe0 == 1'b0 && oe1 == 1'b0, "R1", int'(oe0) + int'(oe1), 0);

    // R10: read to a closed bank, with cke low and nothing open (R9)
    step(1'b0, CMD_NOP, 0, 0, '0);
    step(1'b0, CMD_RD, 0, 0, '0);
    for (int j = 0; j < 5; j++) begin
      step(1'b0, CMD_NOP, 0, 0, '0);
      check(oe0 == 1'b0 && oe1 == 1'b0, "R10", int'(oe0) + int'(oe1), 0);
    end
    // R9: open bank 0 while cke is low; it must be accepted
    step(1'b0, CMD_ACT, 0, 0, '0);
    repeat (3) step(1'b1, CMD_NOP, 0, 0, '0);
    write_sweep(99, 0, 0, 0, "R9");
    step(1'b1, CMD_ACT, 1, 0, '0);
    repeat (2) step(1'b1, CMD_NOP, 0, 0, '0);

    // R3: fill every column of both banks with plain bursts
    for (int b = 0; b < 2; b++)
      for (int c = 0; c < NCOL; c += BL) write_sweep(99, 0, b, c, "R3");

    // R2 R4 R5 R6: freeze at every offset and length during reads
    for (int s = 0; s < 6; s++)
      for (int L = 1; L < 4; L++) read_sweep(s, L, s % 2, (s + L) % NCOL, "");

    // R7: freeze during writes, then read back
    for (int s = 0; s < 6; s++)
      for (int L = 1; L < 4; L++) write_sweep(s, L, L % 2, (s * 3 + L) % NCOL, "R7");

    // R8: commands on frozen edges are dropped
    step(1'b0, CMD_NOP, 0, 0, '0);
    step(1'b0, CMD_NOP, 0, 0, '0);
    step(1'b0, CMD_RD, 0, 0, '0);
    check(oe0 == 1'b0 && oe1 == 1'b0, "R8", int'(oe0) + int'(oe1), 0);
    step(1'b0, CMD_WR, 0, 5, 8'h5A);
    check(oe0 == 1'b0 && oe1 == 1'b0, "R8", int'(oe0) + int'(oe1), 0);
    for (int j = 0; j < 6; j++) begin
      step(1'b1, CMD_NOP, 0, 0, 8'h5A);
      check(oe0 == 1'b0 && oe1 == 1'b0, "R8", int'(oe0) + int'(oe1), 0);
    end
    read_sweep(99, 0, 0, 5, "R8");
    read_sweep(99, 0, 0, 4, "R8");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule